// File: doc/BRIEF.md
# NAND Boot Image Loader

This block runs immediately after reset. When the boot-mode pins select NAND boot, it reads the first 4 KB of an external NAND flash through a simple pin-level flash interface. It writes that data, byte for byte and with no error correction, into the on-chip boot SRAM. The processor is held in reset until the copy has finished. Once the copy is done, the processor is released and begins fetching at address 0, where the boot SRAM is now mapped.

The flash geometry is taken from four strap pins, which are captured once after reset:
- part type: normal or advanced command set;
- page size;
- an extra row-address byte;
- data-bus width of 8 or 16 bits.

When the boot-mode pins select NOR boot, no flash traffic occurs and the processor is released at once. The block also decodes processor addresses, so that either the boot SRAM or the external NOR chip-select 0 answers at address 0, depending on the captured boot mode.

Top module: `nand_boot_loader`

## Requirements
- R1: A captured boot mode of 2'b00 starts the NAND copy. Any other value (2'b01, 2'b10, 2'b11) performs no copy: `nf_ce_n` stays high, no SRAM write occurs, and `boot_done` and `cpu_rst_n` go high within a few cycles of reset release.
- R2: In NAND mode the engine writes exactly 4096 bytes, one write to each SRAM address 0..4095. After that, `bytes_copied` reads 4096.
- R3: Address decode in NAND mode: 0x00000000..0x00000FFF selects the boot SRAM, with `bram_addr` equal to the low 12 address bits. Address decode in NOR mode: addresses below 0x08000000 select `sel_cs0`, and 0x40000000..0x40000FFF selects the boot SRAM. Every other address selects nothing, and the two selects are never high together.
- R4: `cpu_rst_n` stays low from reset until the copy has ended, and it goes high together with `boot_done`.
- R5: The boot-mode and strap pins are captured on the first clock after the internal reset releases. Later changes to them are ignored until the next reset.
- R6: Each page read starts with a command byte 0x00, sent with `nf_cle` high. Column bytes of value zero follow: one byte for a normal part (`strap_adv`=0), two for an advanced part. Then row bytes follow, least significant first: two bytes, or three when `strap_xrow`=1. The row is the page index (0, 1, 2...). Advanced parts then receive a confirm command 0x30. Bytes are latched on the rising edge of `nf_we_n`.
- R7: After addressing a page, the engine waits for `nf_rb` to go high, and it never drives `nf_re_n` low while `nf_rb` is low.
- R8: `strap_big_page`=0 gives 512-byte pages (8 page reads). `strap_big_page`=1 gives 2048-byte pages (2 page reads).
- R9: With `strap_wide`=1, each read strobe carries two bytes. `nf_din[7:0]` goes to the even SRAM address and `nf_din[15:8]` to the next odd one, so 2048 strobes cover the image. With `strap_wide`=0, 4096 strobes are made, using `nf_din[7:0]`.
- R10: Data is written to SRAM exactly as read from the flash, with no ECC check or correction.
- R11: If `nf_rb` stays low for TMO_CYC (default 1024) cycles while waiting, the engine sets `boot_err`, ends the copy, sets `boot_done`, releases `cpu_rst_n`, and `bytes_copied` stops changing.
- R12: Asserting `rst_n` at any time, including mid-copy, aborts the copy. After release, a full new copy starts with no software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 2 | Boot-mode pins (00 = NAND) |
| strap_adv | input | 1 | Advanced flash part: 2 column bytes plus confirm command |
| strap_big_page | input | 1 | 0: 512-byte pages, 1: 2048-byte pages |
| strap_xrow | input | 1 | Third row-address byte |
| strap_wide | input | 1 | 16-bit flash data bus |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb | input | 1 | Ready (1) / busy (0) |
| nf_dout | output | 16 | Command/address byte on bits 7:0 |
| nf_dout_en | output | 1 | Output enable for nf_dout |
| nf_din | input | 16 | Read data from flash |
| sram_we | output | 1 | Boot SRAM byte write enable |
| sram_addr | output | 12 | Boot SRAM byte address |
| sram_wdata | output | 8 | Boot SRAM write data |
| cpu_addr | input | 32 | Processor address to decode |
| sel_bram | output | 1 | Address hits the boot SRAM |
| sel_cs0 | output | 1 | Address hits NOR chip-select 0 |
| bram_addr | output | 12 | Boot SRAM offset for cpu_addr |
| cpu_rst_n | output | 1 | Processor reset, released when copy ends |
| boot_done | output | 1 | Copy finished (or skipped) |
| boot_err | output | 1 | Ready/busy timeout ended the copy |
| bytes_copied | output | 13 | Bytes written to SRAM so far |

## Verification
The copy is run over a table of strap patterns that separate three things: the one- versus two-byte column phase, the two- versus three-byte row phase, and the 512- versus 2048-byte page stride. Each of these is seen in the address-byte count, the row values and the number of page reads. The 8- and 16-bit patterns are told apart by strobe count and by where each half of a word lands. A flash model returns position-dependent data that covers every byte value, so a wrong row, a lost byte or a swapped half is caught by comparing the SRAM contents.

Directed runs cover the following:
- the three non-copy boot modes;
- strap changes after capture;
- a busy line stuck low;
- a reset in the middle of a copy;
- both address maps at their edges.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

  localparam logic [7:0] CMD_PAGE_READ = 8'h00;
  localparam logic [7:0] CMD_READ_GO   = 8'h30;

  typedef struct packed {
    logic adv;
    logic big_page;
    logic xrow;
    logic wide;
  } strap_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_ADR_LO,
    ST_ADR_HI,
    ST_CNF_LO,
    ST_CNF_HI,
    ST_GAP,
    ST_WAIT,
    ST_RD_LO,
    ST_RD_HI,
    ST_WR_HI,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/nbl_rst_sync.sv
module nbl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/nbl_strap_latch.sv
module nbl_strap_latch
  import nbl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_pins,
  input  strap_t     strap_pins,
  output strap_t     cfg,
  output logic       nand_mode,
  output logic       cfg_valid
);

  strap_t cfg_q, cfg_d;
  logic   nand_q, nand_d;
  logic   valid_q, valid_d;
  logic   cap_en;

  assign cap_en = !valid_q;

  always_comb begin
    cfg_d   = cfg_q;
    nand_d  = nand_q;
    valid_d = valid_q;
    if (cap_en) begin
      cfg_d   = strap_pins;
      nand_d  = (mode_pins == 2'b00);
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      nand_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      nand_q  <= nand_d;
      valid_q <= valid_d;
    end
  end

  assign cfg       = cfg_q;
  assign nand_mode = nand_q;
  assign cfg_valid = valid_q;

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q)) |-> ($stable(cfg_q) && $stable(nand_q))); // R5

endmodule

// File: rtl/nbl_seq.sv
module nbl_seq
  import nbl_pkg::*;
#(
  parameter int IMG_BYTES = 4096,
  parameter int SMALL_PG  = 512,
  parameter int LARGE_PG  = 2048,
  parameter int TMO_CYC   = 1024,
  localparam int IMG_AW   = $clog2(IMG_BYTES),
  localparam int CNT_W    = IMG_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strap_t            cfg,
  input  logic              nand_mode,
  input  logic              cfg_valid,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  input  logic              nf_rb,
  output logic [15:0]       nf_dout,
  output logic              nf_dout_en,
  input  logic [15:0]       nf_din,
  output logic              sram_we,
  output logic [IMG_AW-1:0] sram_addr,
  output logic [7:0]        sram_wdata,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  byte_cnt
);

  localparam int LG_SMALL = $clog2(SMALL_PG);
  localparam int LG_LARGE = $clog2(LARGE_PG);
  localparam int TMO_W    = $clog2(TMO_CYC) + 1;
  localparam logic [CNT_W-1:0] IMG_END    = CNT_W'(IMG_BYTES);
  localparam logic [CNT_W-1:0] MASK_SMALL = CNT_W'(SMALL_PG - 1);
  localparam logic [CNT_W-1:0] MASK_LARGE = CNT_W'(LARGE_PG - 1);
  localparam logic [TMO_W-1:0] TMO_LAST   = TMO_W'(TMO_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] bc_q, bc_d;
  logic [2:0]       sub_q, sub_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic [15:0]      cap_q, cap_d;
  logic             err_q, err_d;
  logic             done_q, done_d;

  logic [2:0]       n_col, n_adr, row_idx;
  logic [23:0]      row;
  logic [7:0]       adr_byte;
  logic [CNT_W-1:0] bc_inc, pg_mask;
  logic             img_end, pg_end;

  // Geometry decode from the captured straps
  always_comb begin
    n_col   = cfg.adv ? 3'd2 : 3'd1;
    n_adr   = n_col + (cfg.xrow ? 3'd3 : 3'd2);
    pg_mask = cfg.big_page ? MASK_LARGE : MASK_SMALL;
    row     = cfg.big_page ? 24'(bc_q >> LG_LARGE) : 24'(bc_q >> LG_SMALL);
    row_idx = sub_q - n_col;
    if (sub_q < n_col) begin
      adr_byte = 8'h00;
    end else begin
      case (row_idx)
        3'd0:    adr_byte = row[7:0];
        3'd1:    adr_byte = row[15:8];
        default: adr_byte = row[23:16];
      endcase
    end
    bc_inc  = bc_q + CNT_W'(1);
    img_end = (bc_inc == IMG_END);
    pg_end  = ((bc_inc & pg_mask) == '0);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    bc_d    = bc_q;
    sub_d   = sub_q;
    tmo_d   = tmo_q;
    cap_d   = cap_q;
    err_d   = err_q;
    done_d  = done_q;
    case (state_q)
      ST_IDLE: begin
        if (cfg_valid) begin
          if (nand_mode) state_d = ST_CMD_LO;
          else begin
            state_d = ST_DONE;
            done_d  = 1'b1;
          end
        end
      end
      ST_CMD_LO: state_d = ST_CMD_HI;
      ST_CMD_HI: begin
        state_d = ST_ADR_LO;
        sub_d   = 3'd0;
      end
      ST_ADR_LO: state_d = ST_ADR_HI;
      ST_ADR_HI: begin
        if (sub_q == n_adr - 3'd1) begin
          state_d = cfg.adv ? ST_CNF_LO : ST_GAP;
        end else begin
          sub_d   = sub_q + 3'd1;
          state_d = ST_ADR_LO;
        end
      end
      ST_CNF_LO: state_d = ST_CNF_HI;
      ST_CNF_HI: state_d = ST_GAP;
      ST_GAP: begin
        state_d = ST_WAIT;
        tmo_d   = '0;
      end
      ST_WAIT: begin
        if (nf_rb) begin
          state_d = ST_RD_LO;
        end else if (tmo_q == TMO_LAST) begin
          state_d = ST_DONE;
          err_d   = 1'b1;
          done_d  = 1'b1;
        end else begin
          tmo_d = tmo_q + TMO_W'(1);
        end
      end
      ST_RD_LO: begin
        cap_d   = nf_din;
        state_d = ST_RD_HI;
      end
      ST_RD_HI, ST_WR_HI: begin
        bc_d = bc_inc;
        if (state_q == ST_RD_HI && cfg.wide) begin
          state_d = ST_WR_HI;
        end else if (img_end) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
        end else if (pg_end) begin
          state_d = ST_CMD_LO;
        end else begin
          state_d = ST_RD_LO;
        end
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bc_q    <= '0;
      sub_q   <= '0;
      tmo_q   <= '0;
      cap_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bc_q    <= bc_d;
      sub_q   <= sub_d;
      tmo_q   <= tmo_d;
      cap_q   <= cap_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  // Pin decode from state
  always_comb begin
    nf_ce_n    = (state_q == ST_IDLE) || (state_q == ST_DONE);
    nf_cle     = (state_q == ST_CMD_LO) || (state_q == ST_CMD_HI) ||
                 (state_q == ST_CNF_LO) || (state_q == ST_CNF_HI);
    nf_ale     = (state_q == ST_ADR_LO) || (state_q == ST_ADR_HI);
    nf_we_n    = !((state_q == ST_CMD_LO) || (state_q == ST_ADR_LO) ||
                   (state_q == ST_CNF_LO));
    nf_re_n    = (state_q != ST_RD_LO);
    nf_dout_en = nf_cle || nf_ale;
    if (nf_ale)
      nf_dout = {8'h00, adr_byte};
    else if ((state_q == ST_CNF_LO) || (state_q == ST_CNF_HI))
      nf_dout = {8'h00, CMD_READ_GO};
    else
      nf_dout = {8'h00, CMD_PAGE_READ};
    sram_we    = (state_q == ST_RD_HI) || (state_q == ST_WR_HI);
    sram_addr  = bc_q[IMG_AW-1:0];
    sram_wdata = (state_q == ST_WR_HI) ? cap_q[15:8] : cap_q[7:0];
  end

  assign done     = done_q;
  assign err      = err_q;
  assign byte_cnt = bc_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (bc_q < IMG_END)); // R2
  AST_NOR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !nand_mode) |-> (nf_ce_n && !sram_we)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n)); // R6
  AST_READ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_LO && $past(state_q) == ST_WAIT) |-> $past(nf_rb)); // R7
  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (done_q && $stable(bc_q))); // R11

endmodule

// File: rtl/nbl_addr_map.sv
module nbl_addr_map #(
  parameter int          BRAM_BYTES    = 4096,
  parameter logic [31:0] NOR_BRAM_BASE = 32'h4000_0000,
  parameter int          NOR_BANK_AW   = 27,
  localparam int         BRAM_AW       = $clog2(BRAM_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic               nand_mode,
  input  logic [31:0]        cpu_addr,
  output logic               sel_bram,
  output logic               sel_cs0,
  output logic [BRAM_AW-1:0] bram_addr
);

  logic hit_low, hit_high, hit_bank0;

  always_comb begin
    hit_low   = (cpu_addr[31:BRAM_AW] == '0);
    hit_high  = (cpu_addr[31:BRAM_AW] == NOR_BRAM_BASE[31:BRAM_AW]);
    hit_bank0 = (cpu_addr[31:NOR_BANK_AW] == '0);
    sel_bram  = cfg_valid && (nand_mode ? hit_low : hit_high);
    sel_cs0   = cfg_valid && !nand_mode && hit_bank0;
    bram_addr = cpu_addr[BRAM_AW-1:0];
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_bram && sel_cs0)); // R3

endmodule

// File: rtl/nand_boot_loader.sv
module nand_boot_loader
  import nbl_pkg::*;
#(
  parameter int          IMG_BYTES     = 4096,
  parameter int          SMALL_PG      = 512,
  parameter int          LARGE_PG      = 2048,
  parameter int          TMO_CYC       = 1024,
  parameter logic [31:0] NOR_BRAM_BASE = 32'h4000_0000,
  parameter int          NOR_BANK_AW   = 27,
  localparam int         IMG_AW        = $clog2(IMG_BYTES),
  localparam int         CNT_W         = IMG_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_mode,
  input  logic              strap_adv,
  input  logic              strap_big_page,
  input  logic              strap_xrow,
  input  logic              strap_wide,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  input  logic              nf_rb,
  output logic [15:0]       nf_dout,
  output logic              nf_dout_en,
  input  logic [15:0]       nf_din,
  output logic              sram_we,
  output logic [IMG_AW-1:0] sram_addr,
  output logic [7:0]        sram_wdata,
  input  logic [31:0]       cpu_addr,
  output logic              sel_bram,
  output logic              sel_cs0,
  output logic [IMG_AW-1:0] bram_addr,
  output logic              cpu_rst_n,
  output logic              boot_done,
  output logic              boot_err,
  output logic [CNT_W-1:0]  bytes_copied
);

  logic   rst_n_i;
  strap_t strap_pins, cfg;
  logic   nand_mode, cfg_valid, done, err;

  assign strap_pins = '{adv: strap_adv, big_page: strap_big_page,
                        xrow: strap_xrow, wide: strap_wide};

  nbl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  nbl_strap_latch u_strap (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .mode_pins  (boot_mode),
    .strap_pins (strap_pins),
    .cfg        (cfg),
    .nand_mode  (nand_mode),
    .cfg_valid  (cfg_valid)
  );

  nbl_seq #(
    .IMG_BYTES (IMG_BYTES),
    .SMALL_PG  (SMALL_PG),
    .LARGE_PG  (LARGE_PG),
    .TMO_CYC   (TMO_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .cfg        (cfg),
    .nand_mode  (nand_mode),
    .cfg_valid  (cfg_valid),
    .nf_ce_n    (nf_ce_n),
    .nf_cle     (nf_cle),
    .nf_ale     (nf_ale),
    .nf_we_n    (nf_we_n),
    .nf_re_n    (nf_re_n),
    .nf_rb      (nf_rb),
    .nf_dout    (nf_dout),
    .nf_dout_en (nf_dout_en),
    .nf_din     (nf_din),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .done       (done),
    .err        (err),
    .byte_cnt   (bytes_copied)
  );

  nbl_addr_map #(
    .BRAM_BYTES    (IMG_BYTES),
    .NOR_BRAM_BASE (NOR_BRAM_BASE),
    .NOR_BANK_AW   (NOR_BANK_AW)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cfg_valid (cfg_valid),
    .nand_mode (nand_mode),
    .cpu_addr  (cpu_addr),
    .sel_bram  (sel_bram),
    .sel_cs0   (sel_cs0),
    .bram_addr (bram_addr)
  );

  assign cpu_rst_n = done;
  assign boot_done = done;
  assign boot_err  = err;

  AST_RELEASE_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(cpu_rst_n) |-> (err || !nand_mode ||
                          bytes_copied == CNT_W'(IMG_BYTES))); // R4

endmodule

// File: tb/nand_boot_loader_tb.sv
module nand_boot_loader_tb;

  localparam int IMG  = 4096;
  localparam int BUSY = 20;

  typedef struct packed {
    logic        adv;
    logic        big;
    logic        xrow;
    logic        wide;
    logic [3:0]  pages;
    logic [2:0]  ncyc;
    logic [12:0] strobes;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 3'd3, 13'd4096},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd8, 3'd4, 13'd4096},
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 3'd4, 13'd4096},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd2, 3'd5, 13'd2048},
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'd8, 3'd3, 13'd2048},
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'd8, 3'd5, 13'd4096},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 3'd3, 13'd4096}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  boot_mode;
  logic        strap_adv, strap_big_page, strap_xrow, strap_wide;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_rb, nf_dout_en;
  logic [15:0] nf_dout, nf_din;
  logic        sram_we;
  logic [11:0] sram_addr, bram_addr;
  logic [7:0]  sram_wdata;
  logic [31:0] cpu_addr;
  logic        sel_bram, sel_cs0, cpu_rst_n, boot_done, boot_err;
  logic [12:0] bytes_copied;

  always #5 clk = ~clk;

  nand_boot_loader u_dut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
    .strap_adv(strap_adv), .strap_big_page(strap_big_page),
    .strap_xrow(strap_xrow), .strap_wide(strap_wide),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_rb(nf_rb),
    .nf_dout(nf_dout), .nf_dout_en(nf_dout_en), .nf_din(nf_din),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .cpu_addr(cpu_addr), .sel_bram(sel_bram), .sel_cs0(sel_cs0),
    .bram_addr(bram_addr), .cpu_rst_n(cpu_rst_n), .boot_done(boot_done),
    .boot_err(boot_err), .bytes_copied(bytes_copied)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Model geometry (what the flash really is)
  bit m_adv, m_wide, stuck;
  int m_ncol, m_ncyc, m_pg;

  // Model counters
  int n_cmd, n_conf, n_strobe, n_wr, n_dup, n_data_err, n_row_err, n_addr_err;
  int n_viol, n_ce, acnt, row, ptr, busy_left;
  bit we_prev, re_prev;
  bit written [IMG];

  function automatic logic [7:0] patt(input int a);
    return 8'((a * 37) + (a >> 7));
  endfunction

  assign nf_din = m_wide ? {patt(ptr + 1), patt(ptr)} : {8'h00, patt(ptr)};

  task automatic clear_model();
    n_cmd = 0; n_conf = 0; n_strobe = 0; n_wr = 0; n_dup = 0;
    n_data_err = 0; n_row_err = 0; n_addr_err = 0; n_viol = 0; n_ce = 0;
    acnt = 0; row = 0; ptr = 0; busy_left = 0;
    for (int i = 0; i < IMG; i++) written[i] = 1'b0;
  endtask

  // Flash and SRAM model, evaluated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      nf_rb = 1'b1;
      busy_left = 0;
    end else begin
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0 && !stuck) nf_rb = 1'b1;
      end
      if (!nf_ce_n) n_ce++;
      if (nf_we_n && !we_prev && !nf_ce_n) begin
        if (nf_cle) begin
          if (nf_dout[7:0] == 8'h00) begin
            n_cmd++; acnt = 0; row = 0;
          end else if (nf_dout[7:0] == 8'h30) begin
            n_conf++; nf_rb = 1'b0; busy_left = BUSY;
          end else n_addr_err++;
        end else if (nf_ale) begin
          if (acnt >= m_ncyc) n_addr_err++;
          else begin
            if (acnt < m_ncol) begin
              if (nf_dout[7:0] != 8'h00) n_addr_err++;
            end else row = row | (int'(nf_dout[7:0]) << (8 * (acnt - m_ncol)));
            acnt++;
            if (acnt == m_ncyc) begin
              if (row != n_cmd - 1) n_row_err++;
              ptr = row * m_pg;
              if (!m_adv) begin nf_rb = 1'b0; busy_left = BUSY; end
            end
          end
        end
      end
      if (nf_re_n && !re_prev) begin
        n_strobe++;
        ptr = ptr + (m_wide ? 2 : 1);
      end
      if (!nf_re_n && !nf_rb) n_viol++;
      if (sram_we) begin
        n_wr++;
        if (sram_wdata != patt(int'(sram_addr))) n_data_err++;
        if (written[sram_addr]) n_dup++;
        written[sram_addr] = 1'b1;
      end
    end
    we_prev = nf_we_n;
    re_prev = nf_re_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_geom(input vec_t v);
    m_adv = v.adv; m_wide = v.wide;
    m_ncol = v.adv ? 2 : 1;
    m_ncyc = m_ncol + (v.xrow ? 3 : 2);
    m_pg = v.big ? 2048 : 512;
    strap_adv = v.adv; strap_big_page = v.big;
    strap_xrow = v.xrow; strap_wide = v.wide;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    clear_model();
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (boot_done) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_addr(input logic [31:0] a, input bit eb, input bit ec,
                          input int off, input string req);
    @(posedge clk); #2;
    cpu_addr = a;
    @(negedge clk);
    chk(sel_bram == eb && sel_cs0 == ec, req, {sel_bram, sel_cs0}, {eb, ec});
    if (eb) chk(int'(bram_addr) == off, req, int'(bram_addr), off);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; boot_mode = 2'b00; cpu_addr = '0; stuck = 1'b0;
    nf_rb = 1'b1; we_prev = 1'b1; re_prev = 1'b1;
    set_geom(VECS[0]);
    clear_model();

    // Reset state (R4)
    repeat (3) @(negedge clk);
    chk(cpu_rst_n == 1'b0 && boot_done == 1'b0 && boot_err == 1'b0, "R4 reset",
        {cpu_rst_n, boot_done, boot_err}, 0);
    chk(nf_ce_n && nf_we_n && nf_re_n && !sram_we && bytes_copied == 0,
        "R1 reset pins", {nf_ce_n, nf_we_n, nf_re_n, sram_we}, 4'b1110);

    // Table-driven NAND copies (R2 R6 R8 R9 R10 R7)
    for (int v = 0; v < NV; v++) begin
      boot_mode = 2'b00;
      set_geom(VECS[v]);
      do_reset();
      repeat (20) @(negedge clk);
      chk(cpu_rst_n == 1'b0, "R4 held during copy", cpu_rst_n, 0);
      wait_done(20000);
      chk(boot_done && cpu_rst_n && !boot_err, "R4 release", {boot_done, cpu_rst_n, boot_err}, 3'b110);
      chk(bytes_copied == 13'd4096 && n_wr == IMG && n_dup == 0, "R2 count",
          n_wr - n_dup, IMG);
      chk(n_data_err == 0, "R10 data", n_data_err, 0);
      chk(n_cmd == int'(VECS[v].pages), "R8 pages", n_cmd, int'(VECS[v].pages));
      chk(n_conf == (VECS[v].adv ? int'(VECS[v].pages) : 0), "R6 confirm", n_conf,
          VECS[v].adv ? int'(VECS[v].pages) : 0);
      chk(n_addr_err == 0 && n_row_err == 0, "R6 address", n_addr_err + n_row_err, 0);
      chk(n_strobe == int'(VECS[v].strobes), "R9 strobes", n_strobe, int'(VECS[v].strobes));
      chk(n_viol == 0, "R7 busy", n_viol, 0);
    end

    // NAND address map after the last copy (R3)
    chk_addr(32'h0000_0000, 1, 0, 0, "R3 nand base");
    chk_addr(32'h0000_0FFF, 1, 0, 12'hFFF, "R3 nand top");
    chk_addr(32'h0000_1000, 0, 0, 0, "R3 nand past");
    chk_addr(32'h4000_0010, 0, 0, 0, "R3 nand high");

    // NOR modes: no copy (R1)
    for (int m = 1; m < 4; m++) begin
      boot_mode = 2'(m);
      set_geom(VECS[0]);
      do_reset();
      repeat (20) @(negedge clk);
      chk(boot_done && cpu_rst_n && !boot_err, "R1 nor release", {boot_done, cpu_rst_n}, 2'b11);
      chk(n_ce == 0 && n_wr == 0, "R1 nor silent", n_ce + n_wr, 0);
    end
    chk_addr(32'h0000_0000, 0, 1, 0, "R3 nor base");
    chk_addr(32'h07FF_FFFF, 0, 1, 0, "R3 nor bank top");
    chk_addr(32'h0800_0000, 0, 0, 0, "R3 nor past bank");
    chk_addr(32'h4000_0000, 1, 0, 0, "R3 nor sram base");
    chk_addr(32'h4000_0FFF, 1, 0, 12'hFFF, "R3 nor sram top");
    chk_addr(32'h4000_1000, 0, 0, 0, "R3 nor sram past");

    // Strap and mode changes after capture are ignored (R5)
    boot_mode = 2'b00;
    set_geom(VECS[0]);
    do_reset();
    repeat (8) @(negedge clk);
    strap_big_page = 1'b1; strap_wide = 1'b1; strap_adv = 1'b1; boot_mode = 2'b01;
    wait_done(20000);
    chk(n_cmd == 8 && n_conf == 0 && n_strobe == 4096, "R5 straps held", n_cmd, 8);
    chk(n_data_err == 0 && n_wr == IMG, "R5 data", n_wr, IMG);

    // Reset mid-copy restarts cleanly (R12)
    boot_mode = 2'b00;
    set_geom(VECS[2]);
    do_reset();
    repeat (3000) @(negedge clk);
    @(posedge clk); #2;
    rst_n = 1'b0;
    @(negedge clk);
    chk(cpu_rst_n == 1'b0 && nf_ce_n && bytes_copied == 0, "R12 abort",
        {cpu_rst_n, nf_ce_n}, 2'b01);
    do_reset();
    wait_done(20000);
    chk(boot_done && n_wr == IMG && n_dup == 0 && n_data_err == 0, "R12 restart", n_wr, IMG);

    // Busy line stuck low (R11)
    set_geom(VECS[0]);
    stuck = 1'b1;
    do_reset();
    repeat (500) @(negedge clk);
    chk(cpu_rst_n == 1'b0 && !boot_err, "R11 still waiting", {cpu_rst_n, boot_err}, 0);
    wait_done(3000);
    chk(boot_err && boot_done && cpu_rst_n, "R11 timeout", {boot_err, boot_done, cpu_rst_n}, 3'b111);
    chk(bytes_copied == 0 && n_strobe == 0 && n_wr == 0, "R11 copy ended",
        int'(bytes_copied) + n_strobe, 0);
    repeat (50) @(negedge clk);
    chk(bytes_copied == 0 && nf_ce_n, "R11 frozen", int'(bytes_copied), 0);
    stuck = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule